// File: doc/BRIEF.md
# SPI-Mode Memory Card Command Issuer

This block sends a single command to a memory card that is in SPI mode and returns the first byte the card sends back. The caller presents a 6-bit command index and a 32-bit argument and pulses `start`. The block then builds the six-byte command frame and passes it, one byte at a time, to an external SPI byte shifter. The shifter and the block use a request/acknowledge exchange. Bytes that come back while the frame is going out are thrown away.

Once the frame has gone out, the block sends 0xFF filler bytes and looks at each byte that comes back. The first byte that is not 0xFF is the card's response. If eight filler exchanges pass with nothing but 0xFF coming back, the block reports 0xFF and raises a no-response flag.

Chip select, data-block transfer and the meaning of response bits are handled elsewhere.

Top module: `card_cmd_issuer`

## Requirements
- R1: After reset, `busy`, `done` and `xchg_req` are all low.
- R2: The first frame byte carries 0 in bit 7, 1 in bit 6 and the command index in bits 5..0. Bit 6 is set whatever index is given.
- R3: Frame bytes two to five carry the 32-bit argument, most significant byte first.
- R4: The sixth frame byte is 0x95 when the command index is 0, and 0xFF for every other index.
- R5: After the frame, every exchange sends 0xFF, and there are at most 8 such filler exchanges per command.
- R6: The first received filler-phase byte that is not 0xFF is reported on `resp` with `no_resp` low. No further exchange is requested after it.
- R7: When all 8 filler exchanges return 0xFF, `resp` is 0xFF and `no_resp` is high.
- R8: Bytes received during the six frame exchanges do not affect the result or end the command early, even when they are not 0xFF.
- R9: A `start` pulse while `busy` is high is ignored. The frame in progress is unchanged, and no extra command or `done` follows.
- R10: `done` is high for exactly one clock per command, with `resp`/`no_resp` valid in that cycle and `busy` already low.
- R11: `xchg_req` stays high and `xchg_tx` stays stable from the cycle a byte is offered until the cycle `xchg_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command; only honoured when idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| resp | output | 8 | Card response byte, or 0xFF on timeout |
| no_resp | output | 1 | High when no response arrived within 8 fillers |
| xchg_req | output | 1 | Byte exchange requested |
| xchg_tx | output | 8 | Byte to transmit |
| xchg_ack | input | 1 | Shifter has completed the exchange |
| xchg_rx | input | 8 | Byte received, valid with `xchg_ack` |

## Verification
The hardest cases to reach are the two edges of the response window: a reply on the eighth and last filler exchange, and a card that never answers. The bench reaches both through a card model that can be scripted to place its reply at any filler position, or to place none at all. The model also returns 0x00 during the frame, which tests that the block ignores non-filler bytes at that stage. It acknowledges after a varying number of cycles, so the byte-hold rule is tested across different stall lengths. A second `start` is injected partway through one command, and the scoreboard confirms that neither the byte stream nor the count of `done` pulses changes.

// File: rtl/card_cmd_issuer.sv
module card_cmd_issuer #(
  parameter int POLL_LIMIT = 8,
  parameter logic [7:0] IDLE_CRC = 8'h95,
  parameter logic [7:0] FILL = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  output logic        busy,
  output logic        done,
  output logic [7:0]  resp,
  output logic        no_resp,
  output logic        xchg_req,
  output logic [7:0]  xchg_tx,
  input  logic        xchg_ack,
  input  logic [7:0]  xchg_rx
);

  localparam int FRAME_LEN = 6;
  localparam int CW = $clog2((POLL_LIMIT > FRAME_LEN) ? POLL_LIMIT : FRAME_LEN) + 1;

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_POLL} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [5:0]    idx_q;
  logic [31:0]   arg_q;
  logic [7:0]    frame_byte;

  always_comb begin
    case (cnt)
      CW'(0):  frame_byte = {2'b01, idx_q};
      CW'(1):  frame_byte = arg_q[31:24];
      CW'(2):  frame_byte = arg_q[23:16];
      CW'(3):  frame_byte = arg_q[15:8];
      CW'(4):  frame_byte = arg_q[7:0];
      default: frame_byte = (idx_q == 6'd0) ? IDLE_CRC : FILL;
    endcase
  end

  assign busy     = (st != S_IDLE);
  assign xchg_req = busy;
  assign xchg_tx  = (st == S_FRAME) ? frame_byte : FILL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      idx_q   <= '0;
      arg_q   <= '0;
      done    <= 1'b0;
      resp    <= FILL;
      no_resp <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          idx_q <= cmd_idx;
          arg_q <= cmd_arg;
          cnt   <= '0;
          st    <= S_FRAME;
        end
        S_FRAME: if (xchg_ack) begin
          if (cnt == CW'(FRAME_LEN - 1)) begin
            cnt <= '0;
            st  <= S_POLL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_POLL: if (xchg_ack) begin
          if (xchg_rx != FILL) begin
            resp    <= xchg_rx;
            no_resp <= 1'b0;
            done    <= 1'b1;
            st      <= S_IDLE;
          end else if (cnt == CW'(POLL_LIMIT - 1)) begin
            resp    <= FILL;
            no_resp <= 1'b1;
            done    <= 1'b1;
            st      <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_req && !xchg_ack) |=> (xchg_req && $stable(xchg_tx)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(xchg_ack) && !busy));

  // R7
  timeout_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_resp) |-> (resp == FILL));

  // R6
  stop_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !xchg_req);

endmodule

// File: tb/card_cmd_issuer_test.sv
module card_cmd_issuer_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [5:0]  cmd_idx = 0;
  logic [31:0] cmd_arg = 0;
  logic        busy, done, no_resp, xchg_req, xchg_ack = 0;
  logic [7:0]  resp, xchg_tx, xchg_rx = 8'hFF;

  always #5 clk = ~clk;

  card_cmd_issuer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .busy(busy), .done(done), .resp(resp), .no_resp(no_resp),
    .xchg_req(xchg_req), .xchg_tx(xchg_tx), .xchg_ack(xchg_ack), .xchg_rx(xchg_rx)
  );

  int tests = 0, fails = 0, cycles = 0, done_cnt = 0;
  logic [7:0] exp_tx[$];
  logic [8:0] exp_res[$];
  int reply_at = 0;
  logic [7:0] reply_val = 0;
  int byte_no = 0, wait_cnt = 0, stall = 0;
  logic [7:0] held_tx = 0;
  logic prev_done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrap_up;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      wrap_up();
    end
  end

  // card model and tx scoreboard
  initial forever begin
    @(negedge clk);
    xchg_ack = 0;
    if (xchg_req) begin
      if (wait_cnt == 0) held_tx = xchg_tx;
      else chk(xchg_tx == held_tx, "R11 tx held", xchg_tx, held_tx);
      if (wait_cnt < stall) wait_cnt++;
      else begin
        if (exp_tx.size() == 0) chk(0, "R5/R6 extra exchange", xchg_tx, 0);
        else begin
          logic [7:0] e;
          e = exp_tx.pop_front();
          chk(xchg_tx == e, byte_no == 0 ? "R2 cmd byte" : byte_no < 5 ? "R3 arg byte" :
              byte_no == 5 ? "R4 crc byte" : "R5 filler", xchg_tx, e);
        end
        if (byte_no < 6) xchg_rx = 8'h00;
        else xchg_rx = (byte_no - 6 == reply_at) ? reply_val : 8'hFF;
        xchg_ack = 1;
        byte_no++;
        wait_cnt = 0;
        stall = (stall + 1) % 3;
      end
    end
  end

  // result monitor
  initial forever begin
    @(negedge clk);
    if (done) begin
      logic [8:0] e;
      chk(!prev_done, "R10 single pulse", 1, 0);
      chk(!busy, "R10 busy low", busy, 0);
      chk(exp_tx.size() == 0, "R5/R6 byte count", exp_tx.size(), 0);
      if (exp_res.size() == 0) chk(0, "R9 unexpected done", 1, 0);
      else begin
        e = exp_res.pop_front();
        chk({no_resp, resp} == e, e[8] ? "R7 timeout" : "R6/R8 response", {no_resp, resp}, e);
      end
      done_cnt++;
    end
    prev_done = done;
  end

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                         input int at, input logic [7:0] val, input bit poke);
    int target;
    exp_tx.push_back({2'b01, idx});
    for (int i = 3; i >= 0; i--) exp_tx.push_back(arg[i*8 +: 8]);
    exp_tx.push_back(idx == 0 ? 8'h95 : 8'hFF);
    for (int i = 0; i < ((at < 8) ? at + 1 : 8); i++) exp_tx.push_back(8'hFF);
    exp_res.push_back(at < 8 ? {1'b0, val} : 9'h1FF);
    reply_at = at; reply_val = val; byte_no = 0;
    target = done_cnt + 1;
    @(negedge clk);
    cmd_idx = idx; cmd_arg = arg; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (4) @(negedge clk);
      cmd_idx = ~idx; cmd_arg = ~arg; start = 1;  // R9
      @(negedge clk);
      start = 0;
    end
    while (done_cnt < target) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(!xchg_req && done_cnt == target, "R6/R9 idle after done", done_cnt, target);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1
    chk(!busy && !done && !xchg_req, "R1 reset state", {busy, done, xchg_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !xchg_req, "R1 after release", {busy, xchg_req}, 0);
    run_cmd(6'd0, 32'h0, 0, 8'h01, 0);
    run_cmd(6'd1, 32'h0, 3, 8'h00, 0);
    run_cmd(6'd17, 32'h01234500, 7, 8'h00, 0);
    run_cmd(6'd24, 32'hA5C3_0F81, 8, 8'h00, 0);
    run_cmd(6'd63, 32'hDEADBEEF, 1, 8'h04, 1);
    run_cmd(6'd0, 32'hFFFF_FFFF, 2, 8'h7E, 0);
    chk(exp_res.size() == 0, "R10 all results", exp_res.size(), 0);
    wrap_up();
  end
endmodule